// File: doc/BRIEF.md
# GPIO Port with Control Register File

This block is a small peripheral that sits on a simple synchronous register bus. It holds a set of 16-bit control words and a 16-line general-purpose I/O port. Software reaches it through a 6-bit address, separate read and write enables, 16-bit write data and 16-bit registered read data. A one-cycle error pulse marks any access to an offset that holds no register.

The I/O port has a direction word and a level word. Each output pin carries its level bit gated by its direction bit. The driven pins are only recomputed when software writes the direction word or the level word. External input lines pass through a two-flop synchronizer. When a synchronized input changes, it sets or clears the matching level bit without recomputing the driven pins. Writing the power word with bit 7 set forces two extra bits on. The three interrupt-related words are plain storage only.

Top module: `gpio_ctl_port`

## Requirements
- R1: The offsets 0x00 (mode), 0x04 (divider), 0x10 (clock control), 0x14 (raw event), 0x18 (event mask) and 0x1C (event flags) each store the full 16-bit write value and return it on read.
- R2: Read data is registered: `rdata` shows the addressed word in the cycle after `rd_en` is high, and is 0 in any cycle that follows no read.
- R3: Offset 0x08 is a read-only status word that reads 0x0002. A write to it changes no register and raises no error.
- R4: A write to the power word at offset 0x0C stores the write value ORed with 0x8040 when write bit 7 is 1, and stores it unchanged otherwise.
- R5: Offset 0x20 is the direction word (bit n = 1 makes line n an output). A write to 0x24 or 0x28 stores (write value AND direction) into the level word. Reads of 0x24 and 0x28 both return the level word.
- R6: `pin_out` equals (level AND direction) as it stands after a write to offset 0x20, 0x24 or 0x28, and takes that value at the same clock edge that stores the write. In every other cycle `pin_out` holds its value.
- R7: A change on `pin_in[n]` copies the new value into level bit n at the third rising edge after the change, and leaves `pin_out` unchanged.
- R8: When a level write and a synchronized input change reach the level word at the same edge, the written value wins on every bit. A direction write at that edge keeps the input change and drives `pin_out` from the updated level.
- R9: Any 6-bit offset not listed in R1 to R5 is undefined. A read of it returns 0, a write changes no register, and either access makes `err` high for exactly the following cycle.
- R10: After reset every register and `pin_out` is 0, except the status word, which reads 0x0002.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 6 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| err | output | 1 | High for one cycle after an access to an undefined offset |
| pin_in | input | 16 | External input lines, asynchronous |
| pin_out | output | 16 | Output lines, level gated by direction |

## Verification
A software write to the level word and an input change leaving the synchronizer can land on the same clock edge. The bench provokes this by changing `pin_in` and timing the write so that both reach the level word at that edge, counted from the three synchronizer stages. It then reads the level word back and checks that only the written value, masked by direction, survives. It repeats the timing with a direction write in place of the level write and checks that the input change is kept and that `pin_out` shows the updated level under the new direction.

// File: rtl/gpio_ctl_port.sv
module gpio_ctl_port #(
  parameter int W = 16,
  parameter logic [15:0] STATUS_RST = 16'h0002,
  parameter logic [15:0] PWR_FORCE = 16'h8040
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [5:0]   addr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         err,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out
);
  localparam logic [5:0] O_MODE = 6'h00, O_DIV = 6'h04, O_STAT = 6'h08, O_PWR = 6'h0C;
  localparam logic [5:0] O_CLK = 6'h10, O_RAW = 6'h14, O_MSK = 6'h18, O_FLG = 6'h1C;
  localparam logic [5:0] O_DIR = 6'h20, O_LVW = 6'h24, O_LVR = 6'h28;
  localparam int PWR_TRIG = 7;

  logic [W-1:0] mode_r, div_r, pwr_r, clk_r, raw_r, msk_r, flg_r, dir_r, lvl_r;
  logic [W-1:0] sync1, sync2, sync3;
  logic [W-1:0] rd_mux, lvl_chg, lvl_in, lvl_nxt, dir_nxt;
  logic hit, wr_lvl, wr_dir;

  always_comb begin
    hit = 1'b1;
    rd_mux = '0;
    case (addr)
      O_MODE: rd_mux = mode_r;
      O_DIV:  rd_mux = div_r;
      O_STAT: rd_mux = STATUS_RST;
      O_PWR:  rd_mux = pwr_r;
      O_CLK:  rd_mux = clk_r;
      O_RAW:  rd_mux = raw_r;
      O_MSK:  rd_mux = msk_r;
      O_FLG:  rd_mux = flg_r;
      O_DIR:  rd_mux = dir_r;
      O_LVW, O_LVR: rd_mux = lvl_r;
      default: hit = 1'b0;
    endcase
  end

  assign wr_lvl  = wr_en && (addr == O_LVW || addr == O_LVR);
  assign wr_dir  = wr_en && (addr == O_DIR);
  assign lvl_chg = sync2 ^ sync3;
  assign lvl_in  = (lvl_r & ~lvl_chg) | (sync2 & lvl_chg);
  assign lvl_nxt = wr_lvl ? (wdata & dir_r) : lvl_in;
  assign dir_nxt = wr_dir ? wdata : dir_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
      lvl_r <= '0;
      dir_r <= '0;
      pin_out <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      sync3 <= sync2;
      lvl_r <= lvl_nxt;
      dir_r <= dir_nxt;
      if (wr_lvl || wr_dir) pin_out <= lvl_nxt & dir_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r <= '0;
      div_r <= '0;
      pwr_r <= '0;
      clk_r <= '0;
      raw_r <= '0;
      msk_r <= '0;
      flg_r <= '0;
    end else if (wr_en) begin
      case (addr)
        O_MODE: mode_r <= wdata;
        O_DIV:  div_r <= wdata;
        O_PWR:  pwr_r <= wdata[PWR_TRIG] ? (wdata | PWR_FORCE) : wdata;
        O_CLK:  clk_r <= wdata;
        O_RAW:  raw_r <= wdata;
        O_MSK:  msk_r <= wdata;
        O_FLG:  flg_r <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err <= 1'b0;
    end else begin
      rdata <= rd_en ? rd_mux : '0;
      err <= (rd_en || wr_en) && !hit;
    end
  end

  // R6
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~dir_r) == '0);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == O_DIR || addr == O_LVW || addr == O_LVR)) |=> $stable(pin_out));

  // R5
  lvl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == O_LVW || addr == O_LVR)) |=> (lvl_r & ~$past(dir_r)) == '0);

  // R3
  stat_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == O_STAT) |=> rdata == STATUS_RST);

  // R4
  pwr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == O_PWR && wdata[PWR_TRIG]) |=> (pwr_r & PWR_FORCE) == PWR_FORCE);

  // R9
  bad_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && !hit) |=> (err && rdata == '0));

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |=> !err);
endmodule

// File: tb/gpio_ctl_port_tb.sv
module gpio_ctl_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0, pin_in = '0;
  logic [15:0] rdata, pin_out;
  logic err;

  int n_chk = 0, n_err = 0;
  logic [15:0] m_mode, m_div, m_pwr, m_clk, m_raw, m_msk, m_flg, m_dir, m_lvl, m_pin, m_out;
  logic [15:0] got;
  logic got_err;

  always #5 clk = ~clk;

  gpio_ctl_port u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .err(err), .pin_in(pin_in), .pin_out(pin_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic defined(input logic [5:0] o);
    case (o)
      6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h20, 6'h24, 6'h28: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(input logic [5:0] o);
    case (o)
      6'h00: return m_mode;
      6'h04: return m_div;
      6'h08: return 16'h0002;
      6'h0C: return m_pwr;
      6'h10: return m_clk;
      6'h14: return m_raw;
      6'h18: return m_msk;
      6'h1C: return m_flg;
      6'h20: return m_dir;
      6'h24, 6'h28: return m_lvl;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    got_err = err;
  endtask

  task automatic rd(input logic [5:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    got = rdata;
    got_err = err;
  endtask

  task automatic check_all(input string req);
    for (int o = 0; o < 64; o++) begin
      rd(6'(o));
      chk(req, got, exp_rd(6'(o)));
      chk("R9 err flag", {15'd0, got_err}, {15'd0, !defined(6'(o))});
    end
  endtask

  task automatic settle_inputs();
    repeat (4) @(negedge clk);
    m_lvl = (m_lvl & ~(pin_in ^ m_pin)) | (pin_in & (pin_in ^ m_pin));
    m_pin = pin_in;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    {m_mode, m_div, m_pwr, m_clk, m_raw, m_msk, m_flg, m_dir, m_lvl, m_pin, m_out} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state, R9 undefined offsets read 0 with err
    chk("R10 pin_out reset", pin_out, 16'h0000);
    chk("R2 idle rdata", rdata, 16'h0000);
    check_all("R10 reset read");
    @(negedge clk);
    chk("R9 err one cycle", {15'd0, err}, 16'h0000);

    // R1 plain storage words
    for (int i = 0; i < 8; i++) begin
      logic [5:0] o;
      logic [15:0] v;
      o = (i < 2) ? 6'(i * 4) : 6'(8 + i * 4);
      if (i > 5) continue;
      v = 16'hA5C3 ^ 16'(i * 16'h1111);
      wr(o, v);
      chk("R1 write no err", {15'd0, got_err}, 16'h0000);
      case (o)
        6'h00: m_mode = v; 6'h04: m_div = v; 6'h10: m_clk = v;
        6'h14: m_raw = v; 6'h18: m_msk = v; default: m_flg = v;
      endcase
    end
    check_all("R1 storage readback");
    @(negedge clk);
    chk("R2 rdata zero after no read", rdata, 16'h0000);

    // R3 status write ignored
    wr(6'h08, 16'hFFFF);
    chk("R3 status write no err", {15'd0, got_err}, 16'h0000);
    check_all("R3 status write ignored");

    // R4 power word
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v;
      v = 16'(i * 16'h0F13) ^ ((i % 2 == 1) ? 16'h0080 : 16'h0000);
      v = (i % 2 == 1) ? (v | 16'h0080) : (v & ~16'h0080);
      wr(6'h0C, v);
      m_pwr = v[7] ? (v | 16'h8040) : v;
      rd(6'h0C);
      chk("R4 power store", got, m_pwr);
    end

    // R5 R6 direction and level sweep
    for (int i = 0; i < 16; i++) begin
      logic [15:0] d, v;
      d = 16'h00FF ^ 16'(i * 16'h1357);
      v = 16'hFFFF ^ 16'(i * 16'h2468);
      wr(6'h20, d);
      m_dir = d;
      m_out = m_lvl & m_dir;
      chk("R6 pin_out after dir write", pin_out, m_out);
      wr((i % 2 == 0) ? 6'h24 : 6'h28, v);
      m_lvl = v & m_dir;
      m_out = m_lvl & m_dir;
      chk("R6 pin_out after level write", pin_out, m_out);
      rd(6'h24);
      chk("R5 level via 0x24", got, m_lvl);
      rd(6'h28);
      chk("R5 level via 0x28", got, m_lvl);
      rd(6'h20);
      chk("R5 direction read", got, m_dir);
    end

    // R7 inputs update level only
    wr(6'h20, 16'hFFFF); m_dir = 16'hFFFF;
    wr(6'h24, 16'h0000); m_lvl = 16'h0000; m_out = 16'h0000;
    for (int i = 0; i < 16; i++) begin
      pin_in = 16'(1) << i;
      settle_inputs();
      chk("R7 pin_out unchanged by input", pin_out, m_out);
      rd(6'h28);
      chk("R7 level follows input", got, m_lvl);
    end
    pin_in = 16'hC3A5;
    settle_inputs();
    rd(6'h24);
    chk("R7 level multi-bit input", got, m_lvl);
    chk("R7 pin_out held", pin_out, m_out);
    wr(6'h20, 16'h0FF0); m_dir = 16'h0FF0; m_out = m_lvl & m_dir;
    chk("R6 re-evaluated on dir write", pin_out, m_out);

    // R8 level write collides with input change
    pin_in = pin_in ^ 16'h0FF0;
    @(negedge clk); @(negedge clk);
    wr(6'h24, 16'h5A5A);
    m_pin = pin_in; m_lvl = 16'h5A5A & m_dir; m_out = m_lvl & m_dir;
    chk("R8 pin_out write wins", pin_out, m_out);
    repeat (3) @(negedge clk);
    rd(6'h24);
    chk("R8 level write wins", got, m_lvl);

    // R8 direction write collides with input change
    pin_in = pin_in ^ 16'h00FF;
    @(negedge clk); @(negedge clk);
    wr(6'h20, 16'h3C3C);
    m_lvl = (m_lvl & ~(pin_in ^ m_pin)) | (pin_in & (pin_in ^ m_pin));
    m_pin = pin_in; m_dir = 16'h3C3C; m_out = m_lvl & m_dir;
    chk("R8 dir write keeps input", pin_out, m_out);
    rd(6'h28);
    chk("R8 level after dir collision", got, m_lvl);

    // R9 undefined writes change nothing
    for (int o = 0; o < 64; o++) begin
      if (defined(6'(o))) continue;
      wr(6'(o), 16'hFFFF);
      chk("R9 write err", {15'd0, got_err}, 16'h0001);
      chk("R9 pin_out unchanged", pin_out, m_out);
    end
    @(negedge clk);
    chk("R9 err drops", {15'd0, err}, 16'h0000);
    check_all("R9 no side effect");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule